// File: doc/BRIEF.md
# Nibble-Wide PRBS7 Generator and Checker

This block provides a built-in pattern test for a 4-bit parallel data path. When testing is enabled, a 127-bit maximal-length pseudorandom pattern replaces the normal transmit nibble. Four pattern bits are produced on every clock. Bit 0 of each nibble is the earliest bit in time.

The same enable starts a checker on the receive side. The checker seeds its history from the received bits, so it needs no knowledge of the sender's phase. It then follows the pattern and reports the result on a single pass flag. The pass flag is low while the test is off and until the first lock. It is high while a locked pattern arrives intact. Each bad nibble pulls it low for two clocks. A burst of bad nibbles makes the checker give up lock and hunt again.

Top module: `prbs7_nibble_tester`

## Requirements
- R1: While `test_en` is low, `tx_nib` equals `tx_data` in the same cycle, for any value of `tx_data`.
- R2: While `test_en` is high, `tx_data` is ignored. Nibble k (counting from 0 at the first cycle with `test_en` high) carries pattern bits b[4k+i] on bit i. The pattern rule is b[n] = b[n-6] xor b[n-7], and the seven bits before b[0] are all ones. The first nibble is therefore 4'h0 and the second is 4'h4.
- R3: The transmitted pattern repeats every 127 bits, and the generator history is never all zeros.
- R4: `pass` is low whenever `test_en` is low. Dropping `test_en` clears the checker lock, so lock must be regained after it returns.
- R5: While hunting, each valid received nibble is shifted into the checker history. Lock is declared after 16 consecutive valid nibbles that match the prediction from that history. `pass` stays low until the first lock.
- R6: While locked, and with no recent error, `pass` is high.
- R7: While locked, a valid nibble that differs from the prediction drives `pass` low for exactly the two clocks following the edge that sampled it. A further error during those two clocks restarts the two-clock count.
- R8: A nibble presented with `rx_valid` low changes neither the checker history nor the lock, and does not affect `pass`.
- R9: From lock onward, errored nibbles are counted over consecutive blocks of 32 valid nibbles. Reaching 8 errors within one block drops lock, which leaves `pass` low. The checker then reseeds from received data and can relock to the pattern at any phase.
- R10: Fewer than 8 errored nibbles in any block leaves the lock in place. `pass` returns high once the error pulses have expired.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both generator and checker |
| rst_n | input | 1 | Asynchronous active-low reset |
| test_en | input | 1 | Turns on pattern transmission and checking together |
| tx_data | input | 4 | Normal transmit nibble |
| rx_data | input | 4 | Received nibble, bit 0 earliest in time |
| rx_valid | input | 1 | Marks `rx_data` as a nibble to check |
| tx_nib | output | 4 | Transmit nibble: the pattern or `tx_data` |
| pass | output | 1 | Pattern test result, high when passing |

## Verification
Two of the checker's reactions can land in the same cycle. A fresh error can arrive while the two-clock low pulse of an earlier error is still running. The error that reaches the lock-loss limit also starts a pulse while lock is being dropped. The bench provokes the first case by sending two corrupted nibbles back to back, and expects exactly three low cycles before `pass` returns high. It provokes the second case with a run of sixteen corrupted nibbles. After that run, `pass` must stay low through later good nibbles until a fresh 16-nibble lock, rather than recovering when the pulse ends.

// File: rtl/prbs7_pkg.sv
package prbs7_pkg;
   localparam int HIST_W   = 7;
   localparam int LANE_N   = 4;
   localparam int TAP_NEAR = 5;
   localparam int TAP_FAR  = 6;
   typedef enum logic {CHK_HUNT = 1'b0, CHK_LOCKED = 1'b1} chk_state_t;
endpackage

// File: rtl/prbs7_lane_step.sv
module prbs7_lane_step #(
   parameter int HW    = 7,
   parameter int LANES = 4,
   parameter int TAP_A = 5,
   parameter int TAP_B = 6
) (
   input  logic [HW-1:0]    hist_i,
   output logic [LANES-1:0] bits_o,
   output logic [HW-1:0]    hist_o
);
   if (TAP_A >= HW || TAP_B >= HW || TAP_A == TAP_B) begin : g_bad_taps
      $error("lane_step: taps must be distinct and inside the history");
   end

   // history bit k holds the bit produced k+1 steps ago
   always_comb begin
      logic [HW-1:0] h;
      h = hist_i;
      for (int i = 0; i < LANES; i++) begin
         bits_o[i] = h[TAP_A] ^ h[TAP_B];
         h = {h[HW-2:0], bits_o[i]};
      end
      hist_o = h;
   end
endmodule

// File: rtl/prbs7_gen.sv
module prbs7_gen #(
   parameter int HW    = 7,
   parameter int LANES = 4,
   parameter int TAP_A = 5,
   parameter int TAP_B = 6,
   parameter logic [HW-1:0] SEED = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   output logic [LANES-1:0] nib_o
);
   if (SEED == '0) begin : g_bad_seed
      $error("prbs7_gen: an all-zero seed locks the sequence");
   end

   logic [HW-1:0] state_q, state_nx;

   prbs7_lane_step #(.HW(HW), .LANES(LANES), .TAP_A(TAP_A), .TAP_B(TAP_B)) u_step (
      .hist_i (state_q),
      .bits_o (nib_o),
      .hist_o (state_nx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   state_q <= SEED;
      else if (!en) state_q <= SEED;
      else          state_q <= state_nx;
   end

   assert_seed_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      state_q != '0);
   assert_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> state_q == SEED);
endmodule

// File: rtl/prbs7_chk.sv
module prbs7_chk
   import prbs7_pkg::*;
#(
   parameter int HW        = 7,
   parameter int LANES     = 4,
   parameter int TAP_A     = 5,
   parameter int TAP_B     = 6,
   parameter int LOCK_GOOD = 16,
   parameter int WIN_LEN   = 32,
   parameter int ERR_LIMIT = 8,
   parameter int HOLD_CYC  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [LANES-1:0] rx_i,
   input  logic             rx_valid,
   output logic             pass_o
);
   localparam int GW = $clog2(LOCK_GOOD) + 1;
   localparam int WW = $clog2(WIN_LEN) + 1;
   localparam int EW = $clog2(ERR_LIMIT) + 1;
   localparam int HCW = $clog2(HOLD_CYC + 1) + 1;
   localparam logic [GW-1:0]  GOOD_LAST = GW'(LOCK_GOOD - 1);
   localparam logic [WW-1:0]  WIN_LAST  = WW'(WIN_LEN - 1);
   localparam logic [EW-1:0]  ERR_LAST  = EW'(ERR_LIMIT - 1);
   localparam logic [HCW-1:0] HOLD_INIT = HCW'(HOLD_CYC);

   if (LOCK_GOOD < 2 || WIN_LEN < ERR_LIMIT || ERR_LIMIT < 1 || HOLD_CYC < 1) begin : g_bad_cfg
      $error("prbs7_chk: inconsistent lock or error thresholds");
   end

   chk_state_t     st_q;
   logic [HW-1:0]  hist_q, pred_hist, rx_hist;
   logic [LANES-1:0] pred;
   logic [GW-1:0]  good_q;
   logic [WW-1:0]  win_q;
   logic [EW-1:0]  errs_q;
   logic [HCW-1:0] hold_q;
   logic           mismatch;

   prbs7_lane_step #(.HW(HW), .LANES(LANES), .TAP_A(TAP_A), .TAP_B(TAP_B)) u_pred (
      .hist_i (hist_q),
      .bits_o (pred),
      .hist_o (pred_hist)
   );

   always_comb begin
      rx_hist = hist_q;
      for (int i = 0; i < LANES; i++) rx_hist = {rx_hist[HW-2:0], rx_i[i]};
   end

   assign mismatch = rx_valid && (pred != rx_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= CHK_HUNT; hist_q <= '0; good_q <= '0;
         win_q <= '0; errs_q <= '0; hold_q <= '0;
      end else if (!en) begin
         st_q <= CHK_HUNT; hist_q <= '0; good_q <= '0;
         win_q <= '0; errs_q <= '0; hold_q <= '0;
      end else begin
         if (hold_q != '0) hold_q <= hold_q - 1'b1;
         if (rx_valid) begin
            if (st_q == CHK_HUNT) begin
               hist_q <= rx_hist;
               if (mismatch) good_q <= '0;
               else if (good_q == GOOD_LAST) begin
                  st_q <= CHK_LOCKED; good_q <= '0; win_q <= '0; errs_q <= '0;
               end else good_q <= good_q + 1'b1;
            end else begin
               if (mismatch) hold_q <= HOLD_INIT;
               if (mismatch && errs_q == ERR_LAST) begin
                  st_q <= CHK_HUNT; hist_q <= rx_hist; good_q <= '0;
                  win_q <= '0; errs_q <= '0;
               end else begin
                  hist_q <= pred_hist;
                  if (win_q == WIN_LAST) begin
                     win_q <= '0; errs_q <= '0;
                  end else begin
                     win_q  <= win_q + 1'b1;
                     errs_q <= errs_q + EW'(mismatch);
                  end
               end
            end
         end
      end
   end

   assign pass_o = en && (st_q == CHK_LOCKED) && (hold_q == '0);

   assert_disable_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> st_q == CHK_HUNT);
   assert_lock_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(st_q == CHK_LOCKED) |-> $past(good_q) == GOOD_LAST && $past(rx_valid));
   assert_err_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      en && st_q == CHK_LOCKED && mismatch |=> !pass_o);
   assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      en && !rx_valid |=> $stable(hist_q) && $stable(st_q));
   assert_err_cap_R9: assert property (@(posedge clk) disable iff (!rst_n)
      errs_q < EW'(ERR_LIMIT));
endmodule

// File: rtl/prbs7_nibble_tester.sv
module prbs7_nibble_tester
   import prbs7_pkg::*;
#(
   parameter int LANES     = LANE_N,
   parameter int LOCK_GOOD = 16,
   parameter int WIN_LEN   = 32,
   parameter int ERR_LIMIT = 8,
   parameter int HOLD_CYC  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             test_en,
   input  logic [LANES-1:0] tx_data,
   input  logic [LANES-1:0] rx_data,
   input  logic             rx_valid,
   output logic [LANES-1:0] tx_nib,
   output logic             pass
);
   logic [LANES-1:0] gen_nib;

   prbs7_gen #(.HW(HIST_W), .LANES(LANES), .TAP_A(TAP_NEAR), .TAP_B(TAP_FAR)) u_gen (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (test_en),
      .nib_o (gen_nib)
   );

   prbs7_chk #(
      .HW(HIST_W), .LANES(LANES), .TAP_A(TAP_NEAR), .TAP_B(TAP_FAR),
      .LOCK_GOOD(LOCK_GOOD), .WIN_LEN(WIN_LEN), .ERR_LIMIT(ERR_LIMIT), .HOLD_CYC(HOLD_CYC)
   ) u_chk (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (test_en),
      .rx_i     (rx_data),
      .rx_valid (rx_valid),
      .pass_o   (pass)
   );

   assign tx_nib = test_en ? gen_nib : tx_data;

   assert_pass_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !test_en |-> !pass);
endmodule

// File: tb/prbs7_nibble_tester_test.sv
`timescale 1ns/1ps
module prbs7_nibble_tester_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       test_en = 1'b0;
   logic [3:0] tx_data = '0;
   logic [3:0] rx_data = '0;
   logic       rx_valid = 1'b0;
   logic [3:0] tx_nib;
   logic       pass;

   int total = 0;
   int bad = 0;
   int rx_pos = 0;
   bit seq [127];

   always #4 clk = ~clk;

   prbs7_nibble_tester uut (
      .clk(clk), .rst_n(rst_n), .test_en(test_en), .tx_data(tx_data),
      .rx_data(rx_data), .rx_valid(rx_valid), .tx_nib(tx_nib), .pass(pass)
   );

   function automatic logic [3:0] exp_nib(int k);
      logic [3:0] r;
      for (int i = 0; i < 4; i++) r[i] = seq[(4 * k + i) % 127];
      return r;
   endfunction

   task automatic check(string req, logic [3:0] act, logic [3:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic send(bit corrupt);
      rx_valid = 1'b1;
      rx_data  = exp_nib(rx_pos) ^ {3'b0, corrupt};
      rx_pos++;
      @(negedge clk);
      rx_valid = 1'b0;
   endtask

   task automatic send_good(int n);
      for (int i = 0; i < n; i++) send(1'b0);
   endtask

   initial begin
      bit ext [134];
      for (int i = 0; i < 7; i++) ext[i] = 1'b1;
      for (int n = 7; n < 134; n++) ext[n] = ext[n-6] ^ ext[n-7];
      for (int n = 0; n < 127; n++) seq[n] = ext[n+7];
   end

   initial begin
      #(8 * 150000);
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R4 reset pass", {3'b0, pass}, 4'h0);

      // R1: transparent path with random data
      for (int i = 0; i < 20; i++) begin
         tx_data = 4'($urandom);
         #1 check("R1 bypass", tx_nib, tx_data);
         check("R4 pass off", {3'b0, pass}, 4'h0);
         @(negedge clk);
      end

      // R2, R3: pattern output over more than two periods
      test_en = 1'b1;
      #1 check("R2 first nibble", tx_nib, 4'h0);
      @(negedge clk);
      #1 check("R2 second nibble", tx_nib, 4'h4);
      for (int k = 2; k < 300; k++) begin
         @(negedge clk);
         tx_data = 4'($urandom);
         #1 check("R3 pattern nibble", tx_nib, exp_nib(k));
      end
      @(negedge clk);
      test_en = 1'b0;
      @(negedge clk);
      test_en = 1'b1;

      // R5: acquisition at an arbitrary phase with idle gaps
      rx_pos = 37;
      for (int i = 0; i < 10; i++) begin
         if ($urandom % 4 == 0) @(negedge clk);
         send(1'b0);
      end
      check("R5 no early lock", {3'b0, pass}, 4'h0);
      for (int i = 0; i < 30; i++) begin
         if ($urandom % 4 == 0) @(negedge clk);
         send(1'b0);
      end
      check("R5 locked", {3'b0, pass}, 4'h1);
      for (int i = 0; i < 5; i++) begin
         send(1'b0);
         check("R6 pass steady", {3'b0, pass}, 4'h1);
      end

      // R7: single error pulse
      send(1'b1); check("R7 err cycle1", {3'b0, pass}, 4'h0);
      send(1'b0); check("R7 err cycle2", {3'b0, pass}, 4'h0);
      send(1'b0); check("R7 err recovered", {3'b0, pass}, 4'h1);
      // R7: back-to-back errors restart the pulse
      send(1'b1); check("R7 restart a", {3'b0, pass}, 4'h0);
      send(1'b1); check("R7 restart b", {3'b0, pass}, 4'h0);
      send(1'b0); check("R7 restart c", {3'b0, pass}, 4'h0);
      send(1'b0); check("R7 restart end", {3'b0, pass}, 4'h1);
      send_good(40);

      // R8: garbage with rx_valid low is ignored
      for (int i = 0; i < 6; i++) begin
         rx_data = 4'($urandom);
         @(negedge clk);
         check("R8 idle ignored", {3'b0, pass}, 4'h1);
      end
      send_good(3);
      check("R8 stream intact", {3'b0, pass}, 4'h1);

      // R10: seven scattered errors keep lock
      for (int e = 0; e < 7; e++) begin
         send(1'b1);
         send_good(3);
      end
      check("R10 lock kept", {3'b0, pass}, 4'h1);
      send_good(40);

      // R9: error burst drops lock; relock on a new phase
      for (int e = 0; e < 16; e++) send(1'b1);
      send_good(5);
      check("R9 lock dropped", {3'b0, pass}, 4'h0);
      rx_pos += 50;
      send_good(25);
      check("R9 relocked", {3'b0, pass}, 4'h1);

      // R4: disabling clears the lock
      test_en = 1'b0;
      #1 check("R4 pass off when disabled", {3'b0, pass}, 4'h0);
      @(negedge clk);
      test_en = 1'b1;
      send_good(5);
      check("R4 lock cleared", {3'b0, pass}, 4'h0);
      send_good(20);
      check("R4 relock after enable", {3'b0, pass}, 4'h1);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule